// File: doc/BRIEF.md
# Three-Slot Instruction Decode Grouper

This block sits between a queue of pre-decoded instruction descriptors and three decode slots. Each clock the queue shows its next three entries in program order. Each entry carries a micro-op count, a byte length and a byte offset from the start of its 16-byte fetch line. The grouper decides how many of those entries issue together this cycle, and into which slots. Slot D0 is general-purpose. Slots D1 and D2 are restricted to short single-micro-op instructions. The block reports per-slot valid flags, how many queue entries were consumed, and the number of micro-ops produced.

Grouping is greedy and in order. D0 always takes the head entry. D1 and then D2 are filled while each following entry meets the restricted-slot rules. Grouping stops at the first entry that fails, and that entry becomes the head next cycle.

An entry with more than four micro-ops runs through a two-state machine. In ST_GROUP the "long start" transition fires when such an entry heads the queue with the downstream ready. That cycle emits four micro-ops and moves to ST_LONG. In ST_LONG the block emits four micro-ops per ready cycle from a remaining-count register. The "final chunk" transition returns to ST_GROUP on the ready cycle where four or fewer micro-ops remain. Only on that cycle is the entry consumed. While the downstream ready is low, ST_LONG stays put.

Top module: `decode_grouper`

## Requirements
- R1: While rst_n is low all outputs are zero. Reset also abandons any multi-cycle instruction in progress, so the first cycle after reset groups the queue head afresh.
- R2: With dn_ready high, q_valid[0] high, no multi-cycle instruction in progress and the head needing 1 to 4 micro-ops, the head issues in D0 this cycle whatever its length. slot_vld[0] is 1.
- R3: D1 and D2 only take an entry whose micro-op count is exactly 1 and whose length is 8 bytes or less.
- R4: An entry k (1 or 2) may join the group only if it sits in the same fetch line as entry k-1. That means its offset equals offset(k-1) + length(k-1) exactly, and offset(k) + length(k) is at most 16.
- R5: Grouping is in program order and stops at the first entry that fails. slot_vld is one of 000, 001, 011 or 111. Outside a multi-cycle instruction, take_cnt equals the number of set slot_vld bits.
- R6: A head needing U > 4 micro-ops issues alone in D0 for ceil(U/4) ready cycles. Each cycle but the last emits 4 micro-ops with take_cnt 0. The last emits the remainder (U - 4*(ceil(U/4)-1)) with take_cnt 1. D1 and D2 stay idle throughout.
- R7: While dn_ready is low, slot_vld, take_cnt and uop_sum are zero, and a multi-cycle instruction keeps its progress.
- R8: Only the valid prefix of q_valid is used. Entry 1 counts only if bits 0 and 1 are set, and entry 2 only if all three bits are set. With q_valid[0] low nothing issues.
- R9: uop_sum equals the micro-op total of the issued slots, reaching 6 for a 4-1-1 group. A stream of 2-micro-op entries issues one per cycle in D0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dn_ready | input | 1 | Decode slots can accept a group this cycle |
| q_valid | input | 3 | Valid flags of the three visible queue entries, bit 0 is the head |
| q_uops | input | 3*UOP_W | Micro-op counts, entry k at bits [k*UOP_W +: UOP_W] |
| q_len | input | 3*LEN_W | Byte lengths, entry k at bits [k*LEN_W +: LEN_W] |
| q_off | input | 3*OFF_W | Byte offsets within the fetch line, entry k at bits [k*OFF_W +: OFF_W] |
| slot_vld | output | 3 | Slot D0/D1/D2 occupied this cycle, bit 0 is D0 |
| take_cnt | output | 2 | Queue entries consumed this cycle |
| uop_sum | output | SUM_W | Micro-ops produced this cycle |

## Verification
The assertions check on every cycle the properties that hold at any moment. Slot occupancy forms an in-order prefix. Restricted slots only ever hold single-micro-op entries of 8 bytes or less that end inside the line. Outputs go quiet when dn_ready is low. Every non-final chunk of a long instruction emits exactly four micro-ops alone and is followed by another D0-only cycle. What the assertions cannot show is the exact group size for a given window, the exact contiguity rule, the remainder on the final chunk, and reset abandoning a long instruction. Those come from the bench's directed cases and its seeded random stream compared against a reference function.

// File: rtl/dg_pkg.sv
package dg_pkg;

    typedef enum logic [0:0] {
        ST_GROUP = 1'b0,
        ST_LONG  = 1'b1
    } grp_state_e;

    localparam int unsigned NSLOT = 3;

endpackage

// File: rtl/dg_slot_rule.sv
module dg_slot_rule #(
    parameter int unsigned UOP_W         = 5,
    parameter int unsigned LEN_W         = 5,
    parameter int unsigned OFF_W         = 4,
    parameter int unsigned LINE_BYTES    = 16,
    parameter int unsigned SHORT_MAX_LEN = 8
) (
    input  logic             valid,
    input  logic [UOP_W-1:0] uops,
    input  logic [LEN_W-1:0] len,
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W-1:0] prev_off,
    input  logic [LEN_W-1:0] prev_len,
    output logic             ok
);

    localparam int unsigned EW = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;
    localparam logic [EW-1:0]    LINE_V  = EW'(LINE_BYTES);
    localparam logic [LEN_W-1:0] SHORT_V = LEN_W'(SHORT_MAX_LEN);
    localparam logic [UOP_W-1:0] ONE_V   = UOP_W'(1);

    logic [EW-1:0] prev_end;
    logic [EW-1:0] own_end;
    logic          single_ok;
    logic          short_ok;
    logic          contig_ok;
    logic          line_ok;

    always_comb begin
        prev_end  = EW'(prev_off) + EW'(prev_len);
        own_end   = EW'(off) + EW'(len);
        single_ok = (uops == ONE_V);
        short_ok  = (len <= SHORT_V);
        contig_ok = (EW'(off) == prev_end);
        line_ok   = (own_end <= LINE_V);
        ok        = valid && single_ok && short_ok && contig_ok && line_ok;
    end

endmodule

// File: rtl/dg_long_seq.sv
module dg_long_seq
    import dg_pkg::*;
#(
    parameter int unsigned UOP_W       = 5,
    parameter int unsigned D0_MAX_UOPS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             adv,
    input  logic [UOP_W-1:0] start_uops,
    output grp_state_e       state,
    output logic [UOP_W-1:0] rem,
    output logic             last
);

    localparam logic [UOP_W-1:0] CHUNK_V = UOP_W'(D0_MAX_UOPS);

    grp_state_e       state_q, state_d;
    logic [UOP_W-1:0] rem_q, rem_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GROUP;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        last    = 1'b0;
        unique case (state_q)
            ST_GROUP: begin
                if (start) begin
                    state_d = ST_LONG;
                    rem_d   = start_uops - CHUNK_V;
                end
            end
            ST_LONG: begin
                last = (rem_q <= CHUNK_V);
                if (adv) begin
                    if (last) begin
                        state_d = ST_GROUP;
                        rem_d   = '0;
                    end else begin
                        rem_d = rem_q - CHUNK_V;
                    end
                end
            end
            default: begin
                state_d = ST_GROUP;
                rem_d   = '0;
            end
        endcase
    end

    assign state = state_q;
    assign rem   = rem_q;

endmodule

// File: rtl/decode_grouper.sv
module decode_grouper
    import dg_pkg::*;
#(
    parameter int unsigned UOP_W         = 5,
    parameter int unsigned LEN_W         = 5,
    parameter int unsigned OFF_W         = 4,
    parameter int unsigned LINE_BYTES    = 16,
    parameter int unsigned SHORT_MAX_LEN = 8,
    parameter int unsigned D0_MAX_UOPS   = 4,
    localparam int unsigned SUM_W        = $clog2(D0_MAX_UOPS + NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dn_ready,
    input  logic [NSLOT-1:0]       q_valid,
    input  logic [NSLOT*UOP_W-1:0] q_uops,
    input  logic [NSLOT*LEN_W-1:0] q_len,
    input  logic [NSLOT*OFF_W-1:0] q_off,
    output logic [NSLOT-1:0]       slot_vld,
    output logic [1:0]             take_cnt,
    output logic [SUM_W-1:0]       uop_sum
);

    localparam logic [UOP_W-1:0] D0_MAX_V = UOP_W'(D0_MAX_UOPS);

    logic [NSLOT-1:0] vpre;
    logic [NSLOT-1:0] elig;
    logic [UOP_W-1:0] head_uops;
    logic             head_long;
    logic             long_start;
    grp_state_e       state;
    logic [UOP_W-1:0] rem;
    logic             last;

    always_comb begin
        vpre[0] = q_valid[0];
        for (int k = 1; k < NSLOT; k++) begin
            vpre[k] = vpre[k-1] && q_valid[k];
        end
    end

    assign head_uops  = q_uops[0 +: UOP_W];
    assign head_long  = (head_uops > D0_MAX_V);
    assign long_start = rst_n && dn_ready && vpre[0] && head_long && (state == ST_GROUP);
    assign elig[0]    = vpre[0];

    generate
        for (genvar k = 1; k < NSLOT; k++) begin : g_rule
            dg_slot_rule #(
                .UOP_W        (UOP_W),
                .LEN_W        (LEN_W),
                .OFF_W        (OFF_W),
                .LINE_BYTES   (LINE_BYTES),
                .SHORT_MAX_LEN(SHORT_MAX_LEN)
            ) u_rule (
                .valid   (vpre[k]),
                .uops    (q_uops[k*UOP_W +: UOP_W]),
                .len     (q_len[k*LEN_W +: LEN_W]),
                .off     (q_off[k*OFF_W +: OFF_W]),
                .prev_off(q_off[(k-1)*OFF_W +: OFF_W]),
                .prev_len(q_len[(k-1)*LEN_W +: LEN_W]),
                .ok      (elig[k])
            );
        end
    endgenerate

    dg_long_seq #(
        .UOP_W      (UOP_W),
        .D0_MAX_UOPS(D0_MAX_UOPS)
    ) u_long (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (long_start),
        .adv       (dn_ready),
        .start_uops(head_uops),
        .state     (state),
        .rem       (rem),
        .last      (last)
    );

    always_comb begin
        logic run;
        slot_vld = '0;
        take_cnt = '0;
        uop_sum  = '0;
        if (rst_n && dn_ready) begin
            unique case (state)
                ST_LONG: begin
                    slot_vld[0] = 1'b1;
                    take_cnt    = last ? 2'd1 : 2'd0;
                    uop_sum     = last ? SUM_W'(rem) : SUM_W'(D0_MAX_UOPS);
                end
                ST_GROUP: begin
                    if (vpre[0]) begin
                        slot_vld[0] = 1'b1;
                        if (head_long) begin
                            uop_sum = SUM_W'(D0_MAX_UOPS);
                        end else begin
                            take_cnt = 2'd1;
                            uop_sum  = SUM_W'(head_uops);
                            run      = 1'b1;
                            for (int k = 1; k < NSLOT; k++) begin
                                run = run && elig[k];
                                if (run) begin
                                    slot_vld[k] = 1'b1;
                                    take_cnt    = take_cnt + 2'd1;
                                    uop_sum     = uop_sum + SUM_W'(1);
                                end
                            end
                        end
                    end
                end
                default: begin
                    slot_vld = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/dg_checker.sv
module dg_checker #(
    parameter int unsigned UOP_W         = 5,
    parameter int unsigned LEN_W         = 5,
    parameter int unsigned OFF_W         = 4,
    parameter int unsigned LINE_BYTES    = 16,
    parameter int unsigned SHORT_MAX_LEN = 8,
    parameter int unsigned D0_MAX_UOPS   = 4,
    parameter int unsigned SUM_W         = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dn_ready,
    input logic [2:0]           q_valid,
    input logic [3*UOP_W-1:0]   q_uops,
    input logic [3*LEN_W-1:0]   q_len,
    input logic [3*OFF_W-1:0]   q_off,
    input logic [2:0]           slot_vld,
    input logic [1:0]           take_cnt,
    input logic [SUM_W-1:0]     uop_sum
);

    logic [UOP_W-1:0] u1, u2;
    logic [LEN_W-1:0] l1, l2;
    logic [7:0]       end1, end2;

    always_comb begin
        u1   = q_uops[UOP_W +: UOP_W];
        u2   = q_uops[2*UOP_W +: UOP_W];
        l1   = q_len[LEN_W +: LEN_W];
        l2   = q_len[2*LEN_W +: LEN_W];
        end1 = 8'(q_off[OFF_W +: OFF_W]) + 8'(l1);
        end2 = 8'(q_off[2*OFF_W +: OFF_W]) + 8'(l2);
    end

    p_in_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[2] |-> slot_vld[1]) and (slot_vld[1] |-> slot_vld[0]));

    p_take_le_slots_r5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(take_cnt) <= $countones(slot_vld));

    p_restricted_d1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[1] |-> (u1 == UOP_W'(1)) && (l1 <= LEN_W'(SHORT_MAX_LEN)));

    p_restricted_d2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld[2] |-> (u2 == UOP_W'(1)) && (l2 <= LEN_W'(SHORT_MAX_LEN)));

    p_line_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[1] |-> end1 <= 8'(LINE_BYTES)) and (slot_vld[2] |-> end2 <= 8'(LINE_BYTES)));

    p_ready_low_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_ready |-> (slot_vld == 3'b000) && (take_cnt == 2'd0) && (uop_sum == '0));

    p_valid_prefix_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[0] |-> q_valid[0]) and (slot_vld[1] |-> q_valid[1]) and (slot_vld[2] |-> q_valid[2]));

    p_long_chunk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[0] && take_cnt == 2'd0) |-> (slot_vld[2:1] == 2'b00) && (uop_sum == SUM_W'(D0_MAX_UOPS)));

    p_long_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[0] && take_cnt == 2'd0) |=> (!dn_ready || slot_vld == 3'b001));

    p_sum_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(uop_sum) <= D0_MAX_UOPS + 2);

endmodule

bind decode_grouper dg_checker #(
    .UOP_W        (UOP_W),
    .LEN_W        (LEN_W),
    .OFF_W        (OFF_W),
    .LINE_BYTES   (LINE_BYTES),
    .SHORT_MAX_LEN(SHORT_MAX_LEN),
    .D0_MAX_UOPS  (D0_MAX_UOPS),
    .SUM_W        (SUM_W)
) u_chk (.*);

// File: tb/decode_grouper_bench.sv
module decode_grouper_bench;

    localparam int UW = 5;
    localparam int LW = 5;
    localparam int OW = 4;
    localparam int SW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dn_ready = 1'b0;
    logic [2:0]     q_valid = '0;
    logic [3*UW-1:0] q_uops = '0;
    logic [3*LW-1:0] q_len = '0;
    logic [3*OW-1:0] q_off = '0;
    logic [2:0]     slot_vld;
    logic [1:0]     take_cnt;
    logic [SW-1:0]  uop_sum;

    int n_chk = 0;
    int n_bad = 0;
    int m_rem = 0;
    int bu[3];
    int bl[3];
    int bo[3];
    bit done = 0;

    always #10 clk = ~clk;

    decode_grouper u_decode_grouper (
        .clk(clk), .rst_n(rst_n), .dn_ready(dn_ready), .q_valid(q_valid),
        .q_uops(q_uops), .q_len(q_len), .q_off(q_off),
        .slot_vld(slot_vld), .take_cnt(take_cnt), .uop_sum(uop_sum)
    );

    task automatic drive(input logic [2:0] v);
        q_valid = v;
        for (int k = 0; k < 3; k++) begin
            q_uops[k*UW +: UW] = UW'(bu[k]);
            q_len[k*LW +: LW]  = LW'(bl[k]);
            q_off[k*OW +: OW]  = OW'(bo[k]);
        end
    endtask

    function automatic void expect_out(output int es, output int et, output int eu);
        bit run;
        es = 0; et = 0; eu = 0;
        if (!rst_n || !dn_ready) return;
        if (m_rem > 0) begin
            es = 1; et = (m_rem <= 4) ? 1 : 0; eu = (m_rem > 4) ? 4 : m_rem;
            return;
        end
        if (!q_valid[0]) return;
        es = 1;
        if (bu[0] > 4) begin eu = 4; return; end
        et = 1; eu = bu[0]; run = 1;
        for (int k = 1; k < 3; k++) begin
            run = run && q_valid[k] && bu[k] == 1 && bl[k] <= 8
                  && bo[k] == bo[k-1] + bl[k-1] && bo[k] + bl[k] <= 16;
            if (run) begin es |= (1 << k); et++; eu++; end
        end
    endfunction

    task automatic cmp(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Inputs are driven at the negedge; outputs compared 5 ns later, then model advances at posedge.
    task automatic step(input string tag);
        int es, et, eu;
        #5;
        expect_out(es, et, eu);
        cmp(tag, int'(slot_vld), es, "slot_vld");
        cmp(tag, int'(take_cnt), et, "take_cnt");
        cmp(tag, int'(uop_sum), eu, "uop_sum");
        @(posedge clk);
        if (rst_n && dn_ready) begin
            if (m_rem > 0) m_rem = (m_rem <= 4) ? 0 : m_rem - 4;
            else if (q_valid[0] && bu[0] > 4) m_rem = bu[0] - 4;
        end
        if (!rst_n) m_rem = 0;
        @(negedge clk);
    endtask

    task automatic set3(input int u0, l0, o0, u1, l1, o1, u2, l2, o2);
        bu[0] = u0; bl[0] = l0; bo[0] = o0;
        bu[1] = u1; bl[1] = l1; bo[1] = o1;
        bu[2] = u2; bl[2] = l2; bo[2] = o2;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        set3(1, 2, 0, 1, 2, 2, 1, 2, 4);
        dn_ready = 1'b1;
        drive(3'b111);
        @(negedge clk);
        step("R1 reset quiet");
        rst_n = 1'b1;
        @(negedge clk);

        // R9: 4-1-1 gives 6 micro-ops
        set3(4, 6, 0, 1, 3, 6, 1, 4, 9); drive(3'b111); step("R9 four-one-one");
        // R9/R2: 2-2-2 only D0, long head length
        set3(2, 14, 0, 2, 1, 14, 2, 1, 15); drive(3'b111); step("R9 two-two-two");
        set3(3, 15, 0, 1, 1, 15, 1, 1, 0); drive(3'b111); step("R2 long bytes in D0");
        // R3: D1 with 2 uops / 9 bytes
        set3(1, 1, 0, 2, 2, 1, 1, 1, 3); drive(3'b111); step("R3 D1 two uops");
        set3(1, 1, 0, 1, 2, 1, 1, 9, 3); drive(3'b111); step("R3 D2 nine bytes");
        // R4: line crossing and gap
        set3(1, 4, 8, 1, 5, 12, 1, 1, 1); drive(3'b111); step("R4 crosses line");
        set3(1, 4, 0, 1, 2, 5, 1, 1, 7); drive(3'b111); step("R4 offset gap");
        set3(1, 4, 0, 1, 4, 4, 1, 8, 8); drive(3'b111); step("R4 ends exactly at 16");
        // R8: non-prefix valids
        set3(1, 1, 0, 1, 1, 1, 1, 1, 2); drive(3'b101); step("R8 hole at entry 1");
        drive(3'b110); step("R8 head invalid");
        // R6: 9 micro-ops -> 4,4,1 with a ready-low gap (R7)
        set3(9, 3, 0, 1, 1, 3, 1, 1, 4); drive(3'b111);
        step("R6 long first chunk");
        dn_ready = 1'b0; step("R7 ready low mid long");
        dn_ready = 1'b1; step("R6 long middle chunk");
        step("R6 long final chunk");
        step("R5 after long groups again");
        // R1: reset abandons a long instruction
        set3(12, 2, 0, 1, 1, 2, 1, 1, 3); drive(3'b111); step("R6 start twelve");
        rst_n = 1'b0; step("R1 reset mid long");
        rst_n = 1'b1;
        set3(1, 1, 0, 1, 1, 1, 1, 1, 2); drive(3'b111); step("R1 fresh group after reset");
        set3(8, 1, 0, 1, 1, 1, 1, 1, 2); drive(3'b111);
        step("R6 eight first"); step("R6 eight last");

        for (int i = 0; i < 3000; i++) begin
            dn_ready = ($urandom_range(0, 99) < 85);
            if (m_rem == 0) begin
                int nv;
                logic [2:0] v;
                bo[0] = $urandom_range(0, 15);
                for (int k = 0; k < 3; k++) begin
                    int r = $urandom_range(0, 99);
                    bu[k] = (r < 60) ? 1 : (r < 85) ? $urandom_range(2, 4) : $urandom_range(5, 14);
                    bl[k] = ($urandom_range(0, 99) < 75) ? $urandom_range(1, 8) : $urandom_range(9, 15);
                    if (k > 0) bo[k] = ($urandom_range(0, 99) < 85) ? ((bo[k-1] + bl[k-1]) % 16)
                                                                   : $urandom_range(0, 15);
                end
                nv = $urandom_range(0, 7);
                v = (nv == 0) ? 3'b000 : (nv == 1) ? 3'b001 : (nv == 2) ? 3'b011 :
                    (nv == 3) ? 3'b101 : 3'b111;
                drive(v);
            end
            step("R5 random stream");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule